// File: doc/BRIEF.md
# Cascadable Four-Input Lookup Cell Column

This block is a column of eight configurable logic cells of the kind stacked inside a programmable-logic tile. Each cell has a four-input lookup table whose sixteen answers come from that cell's configuration word, and a flip-flop that registers the lookup result. Two of the four lookup inputs can be taken from inside the column instead of from the cell's own data pins. The top input can take the ripple carry arriving at the cell. The third input can take the unregistered lookup result of the cell below, so that wide functions can be chained without paying a register stage per cell.

The carry enters cell 0 through a selector that picks constant 0, constant 1 or an external carry pin, and then ripples upward as a majority of each cell's carry and two of its data inputs. Only the registered cell outputs leave the column. The unregistered results are seen only by the next cell up. Each cell decides on its own whether the shared reset acts on it at once or at the next clock edge. All configuration is static parallel input.

The column has no stream interface. Every cell output is a register that is loaded on each enabled clock, and there is no back-pressure, so no valid/ready handshake is used.

Top module: `lutcol_column`

## Requirements
- R1: A cell's lookup index is {in3,in2,in1,in0}. Index values 0 through 15 read configuration bits 4,14,15,5,6,3,2,13,12,11,10,9,8,7,1,0 of the cell word, in that index order.
- R2: When bit 16 of a cell word is 1, lookup input in3 is the carry arriving at that cell. Otherwise it is data pin 3 of that cell.
- R3: The carry leaving cell i is the majority of the arriving carry and the cell's own data pins 1 and 2, taken before any substitution. Cell i+1 receives the carry leaving cell i.
- R4: The carry arriving at cell 0 depends on cfg_cin_sel: 2'b00 gives 0, 2'b01 gives 1, and 2'b10 or 2'b11 gives carry_ext.
- R5: For cell i>0, when bit 17 of its word is 1, lookup input in2 is the unregistered lookup result of cell i-1. Bit 17 of cell 0 has no effect.
- R6: With ce high and rst low, q[i] takes the cell's lookup result at the clock edge. It is visible one cycle after the inputs are applied.
- R7: With ce low and rst low, q holds its value across clock edges, whatever the data inputs do.
- R8: When bit 18 of a cell word is 0, rst clears that cell's q to 0 at the next clock edge, regardless of ce.
- R9: When bit 18 of a cell word is 1, rst clears that cell's q to 0 at once, without a clock edge. Cells whose bit 18 is 0 keep their value until the edge.
- R10: After reset, every q bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all cell flip-flops |
| rst | input | 1 | Active-high reset; each cell applies it synchronously or asynchronously |
| ce | input | 1 | Clock enable shared by all cell flip-flops |
| carry_ext | input | 1 | External carry offered to the cell 0 carry selector |
| cfg_cin_sel | input | 2 | Carry selector setting for cell 0 |
| cfg_cell | input | NCELL*19 | Per-cell words; cell i uses bits [i*19 +: 19] (table [15:0], carry-to-in3 16, cascade-to-in2 17, async reset 18) |
| din | input | NCELL*4 | Per-cell data pins; cell i uses bits [i*4 +: 4], bit 0 is in0 |
| q | output | NCELL | Registered cell outputs |

## Verification
Suppose a row is mapped to the wrong configuration bit, or a substitution select is inverted. The registered output of the affected cell then takes a wrong value at the first enabled edge after a stimulus that reaches that row. The error shows one cycle later. A carry or cascade fault appears in that cell and often in every cell above it, within the same cycle, because the chain is combinational. Reset-mode faults show in the same half cycle for the asynchronous cells, and at the very next edge for the synchronous ones. The bench keeps its own model of all eight registers and compares them on every clock, so any of these faults is caught within one cycle of the stimulus that exposes it.

// File: rtl/lutcol_pkg.sv
package lutcol_pkg;
  localparam int TT_W       = 16;
  localparam int SEL_W      = 4;
  localparam int CFG_W      = 19;
  localparam int DIN_W      = 4;

  typedef struct packed {
    logic            arst;       // bit 18
    logic            in2_casc;   // bit 17
    logic            in3_carry;  // bit 16
    logic [TT_W-1:0] tt;         // bits 15:0
  } cell_cfg_t;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'b00,
    CIN_ONE  = 2'b01,
    CIN_EXTA = 2'b10,
    CIN_EXTB = 2'b11
  } cin_sel_e;

  // permuted placement of truth-table rows inside the configuration word
  function automatic logic [SEL_W-1:0] row_bit(input logic [SEL_W-1:0] r);
    logic [SEL_W-1:0] b;
    case (r)
      4'd0:  b = 4'd4;
      4'd1:  b = 4'd14;
      4'd2:  b = 4'd15;
      4'd3:  b = 4'd5;
      4'd4:  b = 4'd6;
      4'd5:  b = 4'd3;
      4'd6:  b = 4'd2;
      4'd7:  b = 4'd13;
      4'd8:  b = 4'd12;
      4'd9:  b = 4'd11;
      4'd10: b = 4'd10;
      4'd11: b = 4'd9;
      4'd12: b = 4'd8;
      4'd13: b = 4'd7;
      4'd14: b = 4'd1;
      default: b = 4'd0;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/lutcol_cin_mux.sv
module lutcol_cin_mux
  import lutcol_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       ext,
  output logic       cin
);
  always_comb begin
    unique case (cin_sel_e'(sel))
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      CIN_EXTA: cin = ext;
      CIN_EXTB: cin = ext;
      default:  cin = 1'b0;
    endcase
  end
endmodule

// File: rtl/lutcol_lut4.sv
module lutcol_lut4
  import lutcol_pkg::*;
(
  input  logic [TT_W-1:0]  tt,
  input  logic [SEL_W-1:0] idx,
  output logic             y
);
  logic [TT_W-1:0] rows;

  // reorder the configuration bits into linear row order
  for (genvar r = 0; r < TT_W; r++) begin : g_row
    assign rows[r] = tt[row_bit(SEL_W'(r))];
  end

  assign y = rows[idx];
endmodule

// File: rtl/lutcol_cell.sv
module lutcol_cell
  import lutcol_pkg::*;
#(
  parameter bit FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  cell_cfg_t        cfg,
  input  logic [DIN_W-1:0] din,
  input  logic             cin,
  input  logic             cas_in,
  output logic             lout,
  output logic             cout,
  output logic             q
);
  localparam bit CASC_OK = !FIRST;

  logic             in3_eff;
  logic             in2_eff;
  logic [SEL_W-1:0] idx;
  logic             arst;

  assign in3_eff = cfg.in3_carry ? cin : din[3];
  assign in2_eff = (cfg.in2_casc && CASC_OK) ? cas_in : din[2];
  assign idx     = {in3_eff, in2_eff, din[1], din[0]};

  lutcol_lut4 u_lut (
    .tt  (cfg.tt),
    .idx (idx),
    .y   (lout)
  );

  assign cout = (din[1] & din[2]) | (din[1] & cin) | (din[2] & cin);

  assign arst = rst & cfg.arst;

  always_ff @(posedge clk or posedge arst) begin
    if (arst)      q <= 1'b0;
    else if (rst)  q <= 1'b0;
    else if (ce)   q <= lout;
  end
endmodule

// File: rtl/lutcol_column.sv
module lutcol_column
  import lutcol_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce,
  input  logic                   carry_ext,
  input  logic [1:0]             cfg_cin_sel,
  input  logic [NCELL*CFG_W-1:0] cfg_cell,
  input  logic [NCELL*DIN_W-1:0] din,
  output logic [NCELL-1:0]       q
);
  logic [NCELL:0]   carry;
  logic [NCELL-1:0] lout_bus;

  lutcol_cin_mux u_cin (
    .sel (cfg_cin_sel),
    .ext (carry_ext),
    .cin (carry[0])
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic casc;
    if (i == 0) begin : g_base
      assign casc = 1'b0;
    end else begin : g_up
      assign casc = lout_bus[i-1];
    end

    lutcol_cell #(.FIRST(i == 0)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .ce     (ce),
      .cfg    (cell_cfg_t'(cfg_cell[i*CFG_W +: CFG_W])),
      .din    (din[i*DIN_W +: DIN_W]),
      .cin    (carry[i]),
      .cas_in (casc),
      .lout   (lout_bus[i]),
      .cout   (carry[i+1]),
      .q      (q[i])
    );
  end
endmodule

// File: rtl/lutcol_column_chk.sv
module lutcol_column_chk
  import lutcol_pkg::*;
#(
  parameter int NCELL = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ce,
  input logic                   carry_ext,
  input logic [1:0]             cfg_cin_sel,
  input logic [NCELL*CFG_W-1:0] cfg_cell,
  input logic [NCELL*DIN_W-1:0] din,
  input logic [NCELL-1:0]       q,
  input logic [NCELL-1:0]       lout_bus,
  input logic                   carry_top
);
  logic [NCELL-1:0] top_pair;
  for (genvar i = 0; i < NCELL; i++) begin : g_pair
    assign top_pair[i] = din[i*DIN_W+1] & din[i*DIN_W+2];
  end

  // R7: disabled enable keeps every register
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

  // R8 / R10: a reset seen at an edge leaves all registers cleared
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R6: enabled edge loads the unregistered results
  p_capture_r6: assert property (@(posedge clk) disable iff (rst)
    ce |=> (q == $past(lout_bus)));

  // R6: steady inputs under a running enable give a steady output
  p_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (ce && $past(ce) && !$past(rst) && $stable(din) && $stable(cfg_cell)
     && $stable(cfg_cin_sel) && $stable(carry_ext)) |=> $stable(q));

  // R3: a top cell whose data pins 1 and 2 are both high forces its carry out
  p_carry_major_r3: assert property (@(posedge clk) disable iff (rst)
    top_pair[NCELL-1] |-> carry_top);
endmodule

bind lutcol_column lutcol_column_chk #(.NCELL(NCELL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ce          (ce),
  .carry_ext   (carry_ext),
  .cfg_cin_sel (cfg_cin_sel),
  .cfg_cell    (cfg_cell),
  .din         (din),
  .q           (q),
  .lout_bus    (lout_bus),
  .carry_top   (carry[NCELL])
);

// File: tb/sim_lutcol_column.sv
module sim_lutcol_column;
  localparam int PER   = 10;
  localparam int N     = 8;
  localparam int CW    = 19;
  localparam int DW    = 4;
  localparam int ROW [16] = '{4,14,15,5,6,3,2,13,12,11,10,9,8,7,1,0};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ce  = 1'b0;
  logic              carry_ext = 1'b0;
  logic [1:0]        cfg_cin_sel = 2'b00;
  logic [N*CW-1:0]   cfg_cell = '0;
  logic [N*DW-1:0]   din = '0;
  logic [N-1:0]      q;

  logic [N-1:0]      mq = '0;
  int                total = 0;
  int                bad = 0;
  string             phase = "R10";

  always #(PER/2) clk = ~clk;

  lutcol_column #(.NCELL(N)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .carry_ext(carry_ext),
    .cfg_cin_sel(cfg_cin_sel), .cfg_cell(cfg_cell), .din(din), .q(q)
  );

  function automatic logic [N-1:0] model_lout();
    logic [N-1:0] res;
    logic c, prev;
    res = '0;
    prev = 1'b0;
    case (cfg_cin_sel)
      2'b00:   c = 1'b0;
      2'b01:   c = 1'b1;
      default: c = carry_ext;
    endcase
    for (int i = 0; i < N; i++) begin
      logic [3:0]    d;
      logic [CW-1:0] w;
      logic          i3, i2, l;
      int            k;
      d  = din[i*DW +: DW];
      w  = cfg_cell[i*CW +: CW];
      i3 = w[16] ? c : d[3];
      i2 = (i > 0 && w[17]) ? prev : d[2];
      k  = ROW[{i3, i2, d[1], d[0]}];
      l  = w[k];
      c  = (d[1] & d[2]) | (d[1] & c) | (d[2] & c);
      prev   = l;
      res[i] = l;
    end
    return res;
  endfunction

  always @(posedge clk) begin
    if (rst)     mq = '0;
    else if (ce) mq = model_lout();
  end

  always @(posedge rst) begin
    for (int i = 0; i < N; i++)
      if (cfg_cell[i*CW + 18]) mq[i] = 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare against the model a quarter period after each rising edge
  always @(posedge clk) begin
    #(PER/4);
    check(q === mq, phase, q, mq);
  end

  function automatic logic [15:0] tt_pass(input int k);
    logic [15:0] t;
    t = '0;
    for (int r = 0; r < 16; r++) t[ROW[r]] = r[k];
    return t;
  endfunction

  task automatic set_word(input int i, input logic [15:0] tt, input bit c3,
                          input bit c2, input bit ar);
    cfg_cell[i*CW +: CW] = {ar, c2, c3, tt};
  endtask

  task automatic rand_din();
    for (int i = 0; i < N; i++) din[i*DW +: DW] = 4'($urandom);
    carry_ext = 1'($urandom);
  endtask

  task automatic rand_cfg();
    for (int i = 0; i < N; i++)
      cfg_cell[i*CW +: CW] = {1'b0, 18'($urandom)};
    cfg_cin_sel = 2'($urandom);
  endtask

  initial begin
    #(PER*200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] held;
    repeat (3) @(negedge clk);
    check(q === '0, "R10", q, '0);
    rst = 1'b0;
    ce  = 1'b1;

    // R1: each row reads its own configuration bit
    phase = "R1";
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) set_word(i, 16'(1) << ROW[r], 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < N; i++) din[i*DW +: DW] = 4'(r);
      @(negedge clk);
      check(q === '1, "R1", q, '1);
      for (int i = 0; i < N; i++) set_word(i, ~(16'(1) << ROW[r]), 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      check(q === '0, "R1", q, '0);
    end

    // R4 / R2: cell 0 passes in3, which is the selected carry
    phase = "R4";
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 2; e++) begin
        logic expv;
        @(negedge clk);
        set_word(0, tt_pass(3), 1'b1, 1'b0, 1'b0);
        cfg_cin_sel = 2'(s);
        carry_ext = 1'(e);
        din[3] = ~din[3];
        expv = (s == 0) ? 1'b0 : (s == 1) ? 1'b1 : 1'(e);
        @(negedge clk);
        check(q[0] === expv, "R4", {7'b0, q[0]}, {7'b0, expv});
      end
    end
    phase = "R2";
    @(negedge clk);
    set_word(0, tt_pass(3), 1'b0, 1'b0, 1'b0);
    cfg_cin_sel = 2'b01;
    din[3] = 1'b0;
    @(negedge clk);
    check(q[0] === 1'b0, "R2", {7'b0, q[0]}, 8'h00);

    // R3: every cell exposes its arriving carry
    phase = "R3";
    for (int i = 0; i < N; i++) set_word(i, tt_pass(3), 1'b1, 1'b0, 1'b0);
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      rand_din();
      cfg_cin_sel = 2'($urandom);
    end

    // R5: cascade copies cell 0 up the column; cell 0 ignores its cascade bit
    phase = "R5";
    for (int n = 0; n < 8; n++) begin
      logic bit0;
      @(negedge clk);
      set_word(0, tt_pass(2), 1'b0, 1'b1, 1'b0);
      for (int i = 1; i < N; i++) set_word(i, tt_pass(2), 1'b0, 1'b1, 1'b0);
      rand_din();
      bit0 = din[2];
      @(negedge clk);
      check(q === {N{bit0}}, "R5", q, {N{bit0}});
    end

    // R6: random configurations and data
    phase = "R6";
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      if (n % 10 == 0) rand_cfg();
      rand_din();
    end

    // R7: enable low holds
    phase = "R7";
    @(negedge clk);
    ce = 1'b0;
    held = q;
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      rand_din();
      check(q === held, "R7", q, held);
    end

    // R8 / R9: even cells asynchronous, odd cells synchronous
    phase = "R9";
    @(negedge clk);
    ce = 1'b1;
    for (int i = 0; i < N; i++) set_word(i, 16'hFFFF, 1'b0, 1'b0, (i % 2) == 0);
    @(negedge clk);
    check(q === '1, "R9", q, '1);
    ce = 1'b0;
    rst = 1'b1;
    #1;
    check(q === 8'hAA, "R9", q, 8'hAA);
    phase = "R8";
    @(negedge clk);
    check(q === '0, "R8", q, '0);
    rst = 1'b0;
    ce = 1'b1;
    @(negedge clk);
    check(q === '1, "R6", q, '1);
    ce = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(q === '0, "R8", q, '0);
    rst = 1'b0;
    ce = 1'b1;
    phase = "R6";
    for (int n = 0; n < 50; n++) begin
      @(negedge clk);
      rand_cfg();
      rand_din();
    end
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule